// File: doc/BRIEF.md
# PHY SuperSpeed Calibration Sequencer

This block applies a short, fixed set of tuning values to the internal control registers of a SuperSpeed PHY. A single start pulse makes it issue three register writes, one after another, through an external control-register port master. The block drives an address/data pair with a one-cycle request strobe and waits for that master to report completion or failure.

The first two writes are constant. One sets the loss-of-signal detector bias and level with override enabled, and the other raises the transmit boost level. The third write programs the receiver-detect measurement time, and its value depends on a 3-bit reference-clock frequency code. That code is captured when the sequence starts. If any write fails, the block abandons the rest of the sequence and flags an error. After all three writes complete, it flags done.

Top module: `ss_cal_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, busy, done, error and the request strobe are all low.
- R2: A start pulse seen while idle raises busy and the request strobe in the next cycle, with address 0x0015 and data 0xA409 (bias 5 in bits 15:13, override enable in bit 10, level 9 in bits 4:0).
- R3: The cycle after the first write is reported done, the second write is requested with address 0x0012 and data 0xA000 (boost level 5 in bits 15:13, all other bits zero).
- R4: The cycle after the second write is reported done, the third write is requested with address 0x1010 and data equal to the measurement time shifted left by 4: code 7 gives 0x20 (data 0x0200), codes 3 and 4 give 0x04 (data 0x0040), and every other code gives 0x08 (data 0x0080).
- R5: The third write uses the frequency code present on the start cycle, whatever the code input does afterwards.
- R6: The request strobe lasts exactly one cycle per write. Address and data stay unchanged until the port master answers, and no further write is requested before that answer.
- R7: In the cycle after the third write is reported done, done is high for exactly one cycle and busy is low.
- R8: If the port master reports an error on any write, then in the next cycle the error output is high for one cycle, busy is low, done stays low, and no further write is requested.
- R9: A start pulse while busy is ignored. It produces no extra request and does not change the code used by the third write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start the calibration sequence (accepted while idle) |
| clk_code_i | input | CODE_W (3) | Reference-clock frequency code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: all writes completed |
| err_o | output | 1 | One-cycle pulse: a write failed, sequence abandoned |
| cr_req_o | output | 1 | One-cycle write request to the port master |
| cr_addr_o | output | ADDR_W (16) | Internal register address of the current write |
| cr_data_o | output | DATA_W (16) | Value of the current write |
| cr_done_i | input | 1 | Port master: current write completed |
| cr_err_i | input | 1 | Port master: current write failed |

## Verification
The properties assume a well-behaved port master. It gives exactly one answer per request, never in the same cycle as the strobe, and never raises done and error together. The stimulus acts as that master: it answers each request one or more cycles after the strobe and holds the answer for a single cycle. It also injects a failure on chosen writes and pulses start in the middle of a sequence, so the abort path and the ignored-start path are both covered under those rules.

// File: rtl/ss_cal_pkg.sv
`timescale 1ns/1ps
package ss_cal_pkg;

  // Number of tuning writes in one calibration pass
  localparam int NUM_STEPS = 3;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  // Internal register addresses, in issue order
  localparam logic [15:0] LOS_ADDR   = 16'h0015;
  localparam logic [15:0] BOOST_ADDR = 16'h0012;
  localparam logic [15:0] RXDET_ADDR = 16'h1010;

  // Loss-of-signal word: bias[15:13]=5, override enable[10], level[4:0]=9
  localparam logic [15:0] LOS_WORD   = (16'd5 << 13) | (16'd1 << 10) | 16'd9;
  // Transmit boost word: level[15:13]=5
  localparam logic [15:0] BOOST_WORD = (16'd5 << 13);

  // Receiver-detect measurement-time field position
  localparam int MEAS_LSB = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cal_word_sel.sv
`timescale 1ns/1ps
module cal_word_sel
  import ss_cal_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic [7:0]  meas_time;
  logic [15:0] meas_word;

  // Measurement time chosen from the reference-clock code
  always_comb begin
    if (code_i == CODE_W'(7))
      meas_time = 8'h20;
    else if (code_i == CODE_W'(3) || code_i == CODE_W'(4))
      meas_time = 8'h04;
    else
      meas_time = 8'h08;
    meas_word = {8'd0, meas_time} << MEAS_LSB;
  end

  always_comb begin
    case (step_i)
      STEP_W'(0): begin
        addr_o = ADDR_W'(LOS_ADDR);
        data_o = DATA_W'(LOS_WORD);
      end
      STEP_W'(1): begin
        addr_o = ADDR_W'(BOOST_ADDR);
        data_o = DATA_W'(BOOST_WORD);
      end
      default: begin
        addr_o = ADDR_W'(RXDET_ADDR);
        data_o = DATA_W'(meas_word);
      end
    endcase
  end

endmodule

// File: rtl/cal_step_ctrl.sv
`timescale 1ns/1ps
module cal_step_ctrl
  import ss_cal_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rsp_done_i,
  input  logic              rsp_err_i,
  output logic [STEP_W-1:0] sel_step_o,
  output logic [CODE_W-1:0] sel_code_o,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic [DATA_W-1:0] word_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_e        st_q;
  logic [STEP_W-1:0] step_q;
  logic [CODE_W-1:0] code_q;

  // Look up the word for the write that will be issued next
  always_comb begin
    if (st_q == ST_IDLE) begin
      sel_step_o = '0;
      sel_code_o = code_i;
    end else begin
      sel_step_o = STEP_W'(step_q + 1'b1);
      sel_code_o = code_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      code_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      req_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      req_o  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            code_q <= code_i;
            step_q <= '0;
            addr_o <= word_addr_i;
            data_o <= word_data_i;
            req_o  <= 1'b1;
            busy_o <= 1'b1;
            st_q   <= ST_REQ;
          end
        end
        ST_REQ: begin
          st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_err_i) begin
            err_o  <= 1'b1;
            busy_o <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (rsp_done_i) begin
            if (step_q == LAST_STEP) begin
              done_o <= 1'b1;
              busy_o <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              step_q <= STEP_W'(step_q + 1'b1);
              addr_o <= word_addr_i;
              data_o <= word_data_i;
              req_o  <= 1'b1;
              st_q   <= ST_REQ;
            end
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          busy_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ss_cal_seq.sv
`timescale 1ns/1ps
module ss_cal_seq
  import ss_cal_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CODE_W-1:0] clk_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cr_req_o,
  output logic [ADDR_W-1:0] cr_addr_o,
  output logic [DATA_W-1:0] cr_data_o,
  input  logic              cr_done_i,
  input  logic              cr_err_i
);

  logic [STEP_W-1:0] sel_step;
  logic [CODE_W-1:0] sel_code;
  logic [ADDR_W-1:0] word_addr;
  logic [DATA_W-1:0] word_data;

  cal_word_sel #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
  ) u_word (
    .step_i (sel_step),
    .code_i (sel_code),
    .addr_o (word_addr),
    .data_o (word_data)
  );

  cal_step_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .code_i      (clk_code_i),
    .rsp_done_i  (cr_done_i),
    .rsp_err_i   (cr_err_i),
    .sel_step_o  (sel_step),
    .sel_code_o  (sel_code),
    .word_addr_i (word_addr),
    .word_data_i (word_data),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .req_o       (cr_req_o),
    .addr_o      (cr_addr_o),
    .data_o      (cr_data_o)
  );

endmodule

// File: rtl/ss_cal_seq_chk.sv
`timescale 1ns/1ps
module ss_cal_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [CODE_W-1:0] clk_code_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              cr_req_o,
  input logic [ADDR_W-1:0] cr_addr_o,
  input logic [DATA_W-1:0] cr_data_o,
  input logic              cr_done_i,
  input logic              cr_err_i
);

  logic waiting;
  assign waiting = busy_o && !cr_req_o;

  // R2: an idle start launches the first write at once
  p_start_first_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && cr_req_o && cr_addr_o == ADDR_W'(16'h0015)));

  // R4: third-write value is one of the three legal measurement words
  p_meas_word_r4: assert property (@(posedge clk) disable iff (rst)
    (cr_req_o && cr_addr_o == ADDR_W'(16'h1010)) |->
      (cr_data_o == DATA_W'(16'h0200) || cr_data_o == DATA_W'(16'h0040) ||
       cr_data_o == DATA_W'(16'h0080)));

  // R6: the strobe is a single-cycle pulse
  p_req_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    cr_req_o |=> !cr_req_o);

  // R6: address and data hold while the answer is pending
  p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
    (waiting && !cr_done_i && !cr_err_i) |=> ($stable(cr_addr_o) && $stable(cr_data_o)));

  // R6: no strobe while idle
  p_no_req_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !cr_req_o);

  // R7: done leaves the block idle and never coincides with error
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !err_o));

  // R8: a failed write ends the sequence
  p_err_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (waiting && cr_err_i) |=> (err_o && !busy_o && !cr_req_o && !done_o));

  // R9: without an answer, a pending write (start or not) gives no new strobe
  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (waiting && !cr_done_i && !cr_err_i) |=> !cr_req_o);

endmodule

bind ss_cal_seq ss_cal_seq_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CODE_W(CODE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .clk_code_i (clk_code_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .cr_req_o   (cr_req_o),
  .cr_addr_o  (cr_addr_o),
  .cr_data_o  (cr_data_o),
  .cr_done_i  (cr_done_i),
  .cr_err_i   (cr_err_i)
);

// File: tb/test_ss_cal_seq.sv
`timescale 1ns/1ps
module test_ss_cal_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [2:0]  clk_code_i;
  logic        busy_o, done_o, err_o, cr_req_o;
  logic [15:0] cr_addr_o, cr_data_o;
  logic        cr_done_i, cr_err_i;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [31:0] q_word[$];
  string       q_tag[$];
  logic [31:0] mon_word;
  string       mon_tag;

  always #4 clk = ~clk;

  ss_cal_seq i_ss_cal_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .clk_code_i(clk_code_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .cr_req_o(cr_req_o), .cr_addr_o(cr_addr_o), .cr_data_o(cr_data_o),
    .cr_done_i(cr_done_i), .cr_err_i(cr_err_i)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_meas(input logic [2:0] code);
    if (code == 3'd7) return 16'h0200;
    else if (code == 3'd3 || code == 3'd4) return 16'h0040;
    else return 16'h0080;
  endfunction

  // Monitor: every strobe is compared with the next expected write
  always @(negedge clk) begin
    if (!rst && cr_req_o) begin
      if (q_word.size() == 0) begin
        chk(1'b0, "R9 unexpected write request", {cr_addr_o, cr_data_o}, 32'h0);
      end else begin
        mon_word = q_word.pop_front();
        mon_tag  = q_tag.pop_front();
        chk({cr_addr_o, cr_data_o} == mon_word, mon_tag, {cr_addr_o, cr_data_o}, mon_word);
      end
    end
  end

  // Driver + port-master model. fail_step 3 means no failure.
  task automatic run_seq(input logic [2:0] code, input int fail_step,
                         input int lat, input bit poke_busy);
    int last;
    logic [15:0] held;
    last = (fail_step < 3) ? fail_step : 2;
    for (int s = 0; s <= last; s++) begin
      if (s == 0) begin
        q_word.push_back({16'h0015, 16'hA409}); q_tag.push_back("R2 first write");
      end else if (s == 1) begin
        q_word.push_back({16'h0012, 16'hA000}); q_tag.push_back("R3 second write");
      end else begin
        q_word.push_back({16'h1010, exp_meas(code)}); q_tag.push_back("R4 R5 third write");
      end
    end
    @(negedge clk); start_i = 1'b1; clk_code_i = code;
    @(negedge clk); start_i = 1'b0; clk_code_i = code ^ 3'b100;
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    for (int s = 0; s <= last; s++) begin
      while (!cr_req_o) @(negedge clk);
      held = cr_addr_o;
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(cr_req_o == 1'b0, "R6 strobe one cycle / waits for answer", cr_req_o, 0);
        chk(cr_addr_o == held, "R6 address held", cr_addr_o, held);
        if (poke_busy && s == 1 && k == 0) begin
          start_i = 1'b1; clk_code_i = 3'd7;   // R9 start while busy
        end else begin
          start_i = 1'b0; clk_code_i = code ^ 3'b100;
        end
      end
      start_i   = 1'b0;
      cr_done_i = (s != fail_step);
      cr_err_i  = (s == fail_step);
      @(negedge clk);
      cr_done_i = 1'b0; cr_err_i = 1'b0;
      if (s == fail_step) begin
        chk(err_o == 1'b1, "R8 error reported", err_o, 1);
        chk(busy_o == 1'b0, "R8 busy dropped", busy_o, 0);
        chk(done_o == 1'b0, "R8 no done", done_o, 0);
      end else if (s == 2) begin
        chk(done_o == 1'b1, "R7 done pulse", done_o, 1);
        chk(busy_o == 1'b0, "R7 busy dropped", busy_o, 0);
        chk(err_o == 1'b0, "R7 no error", err_o, 0);
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0 && err_o == 1'b0, "R7 R8 status pulse one cycle", {done_o, err_o}, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(cr_req_o == 1'b0, "R8 R9 no further write", cr_req_o, 0);
    end
    chk(q_word.size() == 0, "R6 all expected writes issued", q_word.size(), 0);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; clk_code_i = 3'd0;
    cr_done_i = 1'b0; cr_err_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk({busy_o, done_o, err_o, cr_req_o} == 4'b0, "R1 outputs low in reset",
        {busy_o, done_o, err_o, cr_req_o}, 0);
    start_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk({busy_o, done_o, err_o, cr_req_o} == 4'b0, "R1 outputs low after reset",
        {busy_o, done_o, err_o, cr_req_o}, 0);

    run_seq(3'd5, 3, 1, 1'b0);   // R4 code 5
    run_seq(3'd7, 3, 3, 1'b0);   // R4 R5 code 7, input altered after start
    run_seq(3'd3, 3, 2, 1'b0);
    run_seq(3'd4, 3, 1, 1'b0);
    run_seq(3'd0, 3, 1, 1'b0);
    run_seq(3'd1, 3, 2, 1'b0);
    run_seq(3'd6, 3, 1, 1'b0);
    run_seq(3'd2, 3, 1, 1'b0);
    run_seq(3'd5, 0, 2, 1'b0);   // R8 fail first write
    run_seq(3'd7, 1, 1, 1'b0);   // R8 fail second write
    run_seq(3'd3, 2, 4, 1'b0);   // R8 fail third write
    run_seq(3'd4, 3, 3, 1'b1);   // R9 start while busy

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule